// File: doc/BRIEF.md
# Colour-Transform Coefficient Encoder

This block turns one entry of a 3x3 colour-transform matrix into the 16-bit word that a pipe's colour-space converter consumes. The incoming coefficient is a 64-bit sign-magnitude value. The top bit is the sign, and the remaining bits hold an unsigned magnitude with 32 fraction bits. The outgoing word keeps the sign in its top bit. Below the sign sit a 3-bit range code and a 12-bit field, and the field carries a 9-bit mantissa.

The mantissa window slides with the magnitude. Small coefficients keep more fraction bits and large ones keep fewer. The range code that names the window does not increase monotonically with the magnitude. An optional limited-range mode first scales the magnitude by 219/255. This compresses full-swing video levels into the 16..235 band.

The encoder accepts one coefficient per cycle under a valid strobe. It returns the encoded word one clock later.

Top module: `csc_coeff_encoder`

## Requirements
- R1: Output bit 15 equals input bit 63, including for a zero magnitude (negative zero encodes as 0xB000).
- R2: The range code in bits 14:12 depends on the magnitude m (after any limited-range scaling), and the kept fraction-bit count F follows it:

  | Magnitude range | Code | F |
  |---|---|---|
  | m < 0.125 | 3 | 12 |
  | 0.125 <= m < 0.25 | 2 | 11 |
  | 0.25 <= m < 0.5 | 1 | 10 |
  | 0.5 <= m < 1.0 | 0 | 9 |
  | 1.0 <= m < 2.0 | 7 | 8 |
  | m >= 2.0 | 6 | 7 |

  Codes 4 and 5 never appear.
- R3: The 12-bit field in bits 11:0 is built in four steps. Shift m (in units of 2^-32) right by 29-F. Add 4. Saturate at 0xFFF. Clear bits 2:0. Bits 2:0 of the output are therefore always zero.
- R4: When the rounding add exceeds 0xFFF, the field becomes 0xFF8 and the range code does not change. For example, 0x1FFFFFFF encodes as 0x3FF8.
- R5: Any magnitude of 4.0 or more is treated as 0x3_FFFF_FFFF before encoding. For example, 0x7FFF_FFFF_FFFF_FFFF encodes as 0x6FF8.
- R6: With limitedRange high, the magnitude is prepared in four steps:
  1. Clamp it as in R5.
  2. Shift it right by 2.
  3. Multiply it by 0xDBDBDBDB.
  4. Shift the product right by 30.

  The input sign is then reattached, and the result is encoded as in R2 to R5.
- R7: An input of 1.0 (0x1_0000_0000) encodes as 0x7800. The same input encodes as 0x0DC0 with limitedRange high.
- R8: A zero magnitude encodes as range code 3 with a zero field (0x3000).
- R9: validOut is validIn delayed by exactly one clock, and wordOut is the encoding of the coefficient presented with that validIn. While validIn is low, wordOut holds its last value.
- R10: After reset, validOut is 0 and wordOut is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Coefficient on coeffIn is to be encoded |
| coeffIn | input | 64 | Sign (bit 63) and magnitude with 32 fraction bits |
| limitedRange | input | 1 | Apply the 219/255 range compression before encoding |
| validOut | output | 1 | wordOut carries a new encoding |
| wordOut | output | 16 | Sign, range code and mantissa field |

## Verification
A wrong range decision shows up as a bad code in bits 14:12 on the very next validOut. A wrong shift distance shows up as a field that is off by a power of two in that same cycle. Coefficients just below and just above each of the five thresholds expose such errors at once. A broken rounding or saturation step shows up in the field of values whose shifted window ends near 0xFFF or at a rounding midpoint. A fault in the limited-range multiplier changes every scaled coefficient, so the limited identity value 0x0DC0 reveals it on the first such input. Valid-path or hold faults appear as a missing or extra validOut pulse, or as wordOut changing while no input was accepted.

// File: rtl/csc_enc_pkg.sv
package csc_enc_pkg;

  typedef struct packed {
    logic capture;     // register a new encoded word this cycle
    logic useLimited;  // select the range-compressed magnitude
  } encStrobe_t;

endpackage

// File: rtl/csc_enc_ctrl.sv
module csc_enc_ctrl
  import csc_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic       limitedRange,
  output encStrobe_t strobe,
  output logic       validOut
);

  always_comb begin
    strobe.capture    = validIn;
    strobe.useLimited = limitedRange;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  // R9: an accepted coefficient produces a result on the next clock
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);
  // R9: no result appears without an accepted coefficient
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);

endmodule

// File: rtl/csc_range_sel.sv
module csc_range_sel #(
  parameter int FRAC_W = 32,
  parameter int MAG_W  = FRAC_W + 2,
  parameter int NBANDS = 6,
  parameter int BAND_W = $clog2(NBANDS)
) (
  input  logic [MAG_W-1:0]  mag,
  output logic [BAND_W-1:0] band
);

  // Thresholds are 0.125, 0.25, 0.5, 1.0 and 2.0.
  // In units of 2^-FRAC_W they are 2^(FRAC_W-3+k) for k = 0..NBANDS-2.
  logic [NBANDS-2:0] above;

  for (genvar k = 0; k < NBANDS - 1; k++) begin : g_thr
    localparam logic [MAG_W-1:0] THR = MAG_W'(1) << (FRAC_W - 3 + k);
    assign above[k] = (mag >= THR);
  end

  // The comparisons form a thermometer code.
  // Counting the set bits gives the band index.
  always_comb begin
    band = '0;
    for (int k = 0; k < NBANDS - 1; k++) begin
      band = band + BAND_W'(above[k]);
    end
  end

endmodule

// File: rtl/csc_enc_datapath.sv
module csc_enc_datapath
  import csc_enc_pkg::*;
#(
  parameter int IN_W    = 64,
  parameter int FRAC_W  = 32,
  parameter int MANT_W  = 9,
  parameter int FIELD_W = 12,
  parameter int EXP_W   = 3,
  parameter logic [FRAC_W-1:0] LIMITED_K = 32'hDBDBDBDB,
  localparam int OUT_W  = 1 + EXP_W + FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  encStrobe_t       strobe,
  input  logic [IN_W-1:0]  coeffIn,
  output logic [OUT_W-1:0] wordOut
);

  localparam int RAW_W   = IN_W - 1;
  localparam int MAG_W   = FRAC_W + 2;          // magnitudes below 4.0
  localparam int PAD_W   = FIELD_W - MANT_W;    // cleared low bits
  localparam int BASE_SH = FRAC_W - MANT_W - 6; // shift in the lowest band
  localparam int NBANDS  = 6;
  localparam int BAND_W  = $clog2(NBANDS);
  localparam int PROD_W  = 2 * FRAC_W;
  localparam logic [MAG_W-1:0] MAG_MAX = '1;
  localparam logic [FIELD_W:0] ROUND_ADD = (FIELD_W + 1)'(1) << (PAD_W - 1);

  logic             signBit;
  logic [RAW_W-1:0] rawMag;
  logic [MAG_W-1:0] clampedMag;
  logic [FRAC_W-1:0] quarterMag;
  logic [PROD_W-1:0] product;
  logic [MAG_W-1:0] limitedMag;
  logic [MAG_W-1:0] encMag;
  logic [BAND_W-1:0] band;
  logic [EXP_W-1:0] rangeCode;
  logic [MAG_W-1:0] windowFull;
  logic [FIELD_W-1:0] window;
  logic [FIELD_W:0] rounded;
  logic [FIELD_W-1:0] satField;
  logic [FIELD_W-1:0] field;

  assign signBit = coeffIn[IN_W-1];
  assign rawMag  = coeffIn[RAW_W-1:0];

  // Clamp to just below 4.0.
  assign clampedMag = (|rawMag[RAW_W-1:MAG_W]) ? MAG_MAX : rawMag[MAG_W-1:0];

  // Limited-range prescale:
  // quarter the magnitude, multiply by 219/255 * 2^FRAC_W, then renormalise.
  assign quarterMag = clampedMag[MAG_W-1:2];
  assign product    = {{FRAC_W{1'b0}}, quarterMag} * {{FRAC_W{1'b0}}, LIMITED_K};
  assign limitedMag = product[PROD_W-1:FRAC_W-2];

  assign encMag = strobe.useLimited ? limitedMag : clampedMag;

  csc_range_sel #(
    .FRAC_W (FRAC_W),
    .MAG_W  (MAG_W),
    .NBANDS (NBANDS),
    .BAND_W (BAND_W)
  ) rangeSel_i (
    .mag  (encMag),
    .band (band)
  );

  // The code steps down from 3 and wraps: 3,2,1,0,7,6.
  assign rangeCode = EXP_W'(3) - EXP_W'(band);

  // Sliding window: each band above the lowest keeps one fewer fraction bit.
  assign windowFull = encMag >> (BASE_SH + int'(band));
  assign window     = windowFull[FIELD_W-1:0];
  assign rounded    = {1'b0, window} + ROUND_ADD;
  assign satField   = rounded[FIELD_W] ? {FIELD_W{1'b1}} : rounded[FIELD_W-1:0];
  assign field      = {satField[FIELD_W-1:PAD_W], {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst)                 wordOut <= '0;
    else if (strobe.capture) wordOut <= {signBit, rangeCode, field};
  end

  // R1: the sign travels unchanged into the registered word
  p_sign_copy_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> (wordOut[OUT_W-1] == $past(coeffIn[IN_W-1])));
  // R2: codes 4 and 5 are never produced
  p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (wordOut[OUT_W-2 -: EXP_W] != EXP_W'(4)) && (wordOut[OUT_W-2 -: EXP_W] != EXP_W'(5)));
  // R3: the bits below the mantissa stay clear
  p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
    wordOut[PAD_W-1:0] == '0);
  // R9: the word holds while nothing is accepted
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !strobe.capture |=> $stable(wordOut));

endmodule

// File: rtl/csc_coeff_encoder.sv
module csc_coeff_encoder
  import csc_enc_pkg::*;
#(
  parameter int IN_W    = 64,
  parameter int FRAC_W  = 32,
  parameter int MANT_W  = 9,
  parameter int FIELD_W = 12,
  parameter int EXP_W   = 3,
  localparam int OUT_W  = 1 + EXP_W + FIELD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             validIn,
  input  logic [IN_W-1:0]  coeffIn,
  input  logic             limitedRange,
  output logic             validOut,
  output logic [OUT_W-1:0] wordOut
);

  encStrobe_t strobe;

  csc_enc_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .validIn      (validIn),
    .limitedRange (limitedRange),
    .strobe       (strobe),
    .validOut     (validOut)
  );

  csc_enc_datapath #(
    .IN_W    (IN_W),
    .FRAC_W  (FRAC_W),
    .MANT_W  (MANT_W),
    .FIELD_W (FIELD_W),
    .EXP_W   (EXP_W)
  ) datapath_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .coeffIn (coeffIn),
    .wordOut (wordOut)
  );

endmodule

// File: tb/csc_coeff_encoder_tb_top.sv
module csc_coeff_encoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [63:0] coeffIn = '0;
  logic        limitedRange = 1'b0;
  logic        validOut;
  logic [15:0] wordOut;

  int checkCount = 0;
  int failCount  = 0;

  typedef struct {
    logic [15:0] expWord;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [15:0] lastExp = 16'h0000;

  always #5 clk = ~clk;

  csc_coeff_encoder dut_i (
    .clk          (clk),
    .rst          (rst),
    .validIn      (validIn),
    .coeffIn      (coeffIn),
    .limitedRange (limitedRange),
    .validOut     (validOut),
    .wordOut      (wordOut)
  );

  // Reference encoder, written directly from the requirement text
  function automatic logic [15:0] refEncode(input logic [63:0] c, input logic lim);
    longint unsigned mag;
    longint unsigned quarter;
    longint unsigned prod;
    longint unsigned fld;
    int fb;
    logic [2:0] code;
    mag = {1'b0, c[62:0]};
    if (mag > 64'h3_FFFF_FFFF) mag = 64'h3_FFFF_FFFF;            // R5
    if (lim) begin                                                // R6
      quarter = mag >> 2;
      prod = quarter * 64'hDBDB_DBDB;
      mag = prod >> 30;
    end
    if (mag < 64'h2000_0000)      begin code = 3'd3; fb = 12; end // R2
    else if (mag < 64'h4000_0000) begin code = 3'd2; fb = 11; end
    else if (mag < 64'h8000_0000) begin code = 3'd1; fb = 10; end
    else if (mag < 64'h1_0000_0000) begin code = 3'd0; fb = 9; end
    else if (mag < 64'h2_0000_0000) begin code = 3'd7; fb = 8; end
    else                          begin code = 3'd6; fb = 7; end
    fld = (mag >> (29 - fb)) + 4;                                 // R3
    if (fld > 64'hFFF) fld = 64'hFFF;                             // R4
    fld = fld & 64'hFF8;
    return {c[63], code, fld[11:0]};                              // R1
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] c, input logic lim, input string tag);
    expItem_t it;
    @(negedge clk);
    validIn = 1'b1;
    coeffIn = c;
    limitedRange = lim;
    it.expWord = refEncode(c, lim);
    it.tag = tag;
    expQ.push_back(it);
    lastExp = it.expWord;
  endtask

  // Monitor: compare every result against the queued expectation
  always @(negedge clk) begin
    if (!rst && validOut) begin
      if (expQ.size() == 0) begin
        checkCount++;
        failCount++;
        $display("FAIL R9: unexpected validOut, actual 0x%04h expected none", wordOut);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, wordOut, it.expWord);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset word", wordOut, 16'h0000);
    check("R10 reset valid", {15'b0, validOut}, 16'h0000);
    rst = 1'b0;

    // Fixed anchors checked against hand-computed words
    check("R7 model identity", refEncode(64'h1_0000_0000, 1'b0), 16'h7800);
    check("R7 model limited identity", refEncode(64'h1_0000_0000, 1'b1), 16'h0DC0);
    check("R8 model zero", refEncode(64'h0, 1'b0), 16'h3000);
    check("R4 model saturate", refEncode(64'h1FFF_FFFF, 1'b0), 16'h3FF8);
    check("R5 model clamp", refEncode(64'h7FFF_FFFF_FFFF_FFFF, 1'b0), 16'h6FF8);

    drive(64'h0, 1'b0, "R8 zero");
    drive(64'h8000_0000_0000_0000, 1'b0, "R1 negative zero");
    drive(64'h1_0000_0000, 1'b0, "R7 identity");
    drive(64'h1_0000_0000, 1'b1, "R7 R6 limited identity");
    drive(64'h8000_0000_8000_0000, 1'b0, "R1 R2 minus half");
    drive(64'h4CCC_CCCC, 1'b0, "R3 rounding 0.3");
    drive(64'h3333_3333, 1'b0, "R2 band 0.2");
    drive(64'h1999_9999, 1'b0, "R2 band 0.1");
    drive(64'h1FFF_FFFF, 1'b0, "R4 saturate below 0.125");
    drive(64'h2000_0000, 1'b0, "R2 threshold 0.125");
    drive(64'h1_8000_0000, 1'b0, "R2 band 1.5");
    drive(64'h1_FFFF_FFFF, 1'b0, "R4 saturate below 2.0");
    drive(64'h3_0000_0000, 1'b0, "R2 band 3.0");
    drive(64'h7FFF_FFFF_FFFF_FFFF, 1'b0, "R5 clamp huge");
    drive(64'h4_0000_0000, 1'b0, "R5 clamp 4.0");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R6 R5 limited clamp negative");
    drive(64'h8000_0000_3000_0000, 1'b1, "R6 limited negative small");
    drive(64'h2_4000_0000, 1'b1, "R6 limited 2.25");
    lfsr = 64'h1234_5678_9ABC_DEF1;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      drive({lfsr[63], 27'b0, lfsr[35:0] >> (i % 8)}, lfsr[5], "R2 R3 R6 sweep");
    end

    // R9: idle cycles with changing inputs must leave the word alone
    @(negedge clk);
    validIn = 1'b0;
    coeffIn = 64'h1_0000_0000;
    limitedRange = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      coeffIn = coeffIn + 64'h1357_9BDF;
      @(negedge clk);
      check("R9 hold word", wordOut, lastExp);
      check("R9 idle valid", {15'b0, validOut}, 16'h0000);
    end
    check("R9 queue drained", 16'(expQ.size()), 16'h0000);

    $display("  %0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule